// File: doc/BRIEF.md
# Segment Table Address Translator

This block maps a 14-bit virtual address to a 16-bit physical address through a table of four segment descriptors. The two most significant address bits pick the descriptor. The other twelve bits form an offset. The offset is compared against the descriptor's length and added to its start address. Each descriptor also carries read, write and execute permissions and a valid flag. A reference to an unused segment faults. So does an offset past the end of the segment, and so does an access type that the segment does not permit. A fault stops the address-valid strobe and reports a fault code instead.

Privileged software loads the descriptors through a small address/data/write-enable port. It reads them back through the same port, so it can save and restore them on a context switch. If the write-protect fault is caught in software, read-only segments can be used to share memory copy-on-write after a process fork. Translation results are registered and appear one clock after the request. A table write takes effect on the clock edge that follows it.

Top module: `seg_xlate`

## Requirements
- R1: After reset the table holds the following. Segment 0: start 0x4000, length 0x700, read+execute. Segment 1: start 0x0000, length 0x500, read+write. Segment 2: invalid, with start, length and permissions all zero. Segment 3: start 0x2000, length 0x1000, read+write.
- R2: A request whose segment is valid, in range and permitted raises `paddr_vld_o` one cycle later with `fault_o` = 0. `paddr_o` then equals start + offset modulo 2^16.
- R3: If the offset is greater than or equal to the segment length, the result is fault code 1 (bounds) and `paddr_vld_o` stays low.
- R4: A request to a segment whose valid bit is clear gives fault code 2 (invalid), whatever the offset and access type.
- R5: `req_acc_i` selects the permission checked: 0 checks read, 1 checks write, 2 checks execute. Value 3 always fails. A missing permission gives fault code 3 (protection).
- R6: When several conditions hold at once, the fault reported follows the order invalid, then bounds, then protection.
- R7: A write on the configuration port takes effect on the next clock edge. A translation requested in the same cycle uses the old contents. The port address is {segment[1:0], field[1:0]}. Field 0 is the start (16 bits). Field 1 is the length (13 bits, with upper data bits dropped). Field 2 holds the permissions: bit0 read, bit1 write, bit2 execute, bit3 valid. Field 3 reads as zero and ignores writes. `cfg_rdata_o` shows the addressed field, zero-extended, in the same cycle.
- R8: In the cycle after a clock edge with no request, `paddr_vld_o` is low and `fault_o` is 0.
- R9: `paddr_o` is zero whenever `paddr_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | 14 | Virtual address: segment in [13:12], offset in [11:0] |
| req_acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute |
| cfg_we_i | input | 1 | Table write enable |
| cfg_addr_i | input | 4 | Table address {segment, field} |
| cfg_wdata_i | input | 16 | Table write data |
| cfg_rdata_o | output | 16 | Table read data for cfg_addr_i |
| paddr_vld_o | output | 1 | Physical address valid |
| paddr_o | output | 16 | Physical address |
| fault_o | output | 2 | Fault: 0 none, 1 bounds, 2 invalid, 3 protection |

## Verification
Several properties are checked on every cycle. A valid strobe never appears together with a fault. Every request ends in exactly one of the two. An idle cycle leaves both outputs quiet, and the address is zero while the strobe is low. The invalid and bounds fault codes are also checked against the registered table. The bench's scenarios cover the rest. They check the actual sums, including wrap-around, and the permission check for each access type. They check fault priority when conditions overlap, the reset contents read back through the port, and the old-contents behaviour when a write and a translation fall in the same cycle.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int VA_W     = 14;
  localparam int SEG_BITS = 2;
  localparam int PA_W     = 16;
  localparam int OFF_W    = VA_W - SEG_BITS;
  localparam int NSEG     = 1 << SEG_BITS;
  localparam int LEN_W    = OFF_W + 1;
  localparam int FLD_W    = 2;
  localparam int CFG_AW   = SEG_BITS + FLD_W;

  localparam logic [FLD_W-1:0] FLD_BASE  = 2'd0;
  localparam logic [FLD_W-1:0] FLD_LIMIT = 2'd1;
  localparam logic [FLD_W-1:0] FLD_PERM  = 2'd2;

  typedef enum logic [1:0] {FLT_NONE, FLT_BOUNDS, FLT_INVALID, FLT_PROT} fault_e;
  typedef enum logic [1:0] {ACC_READ, ACC_WRITE, ACC_EXEC, ACC_RSVD} acc_e;

  typedef struct packed {
    logic [PA_W-1:0]  base;
    logic [LEN_W-1:0] limit;
    logic             ok;
    logic             x;
    logic             w;
    logic             r;
  } seg_ent_t;

  function automatic seg_ent_t seg_reset(input int unsigned idx);
    seg_ent_t e;
    e = '0;
    case (idx)
      0: begin e.base = PA_W'(16'h4000); e.limit = LEN_W'(13'h0700); e.ok = 1'b1; e.r = 1'b1; e.x = 1'b1; end
      1: begin e.base = PA_W'(16'h0000); e.limit = LEN_W'(13'h0500); e.ok = 1'b1; e.r = 1'b1; e.w = 1'b1; end
      3: begin e.base = PA_W'(16'h2000); e.limit = LEN_W'(13'h1000); e.ok = 1'b1; e.r = 1'b1; e.w = 1'b1; end
      default: e = '0;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [CFG_AW-1:0]       addr_i,
  input  logic [PA_W-1:0]         wdata_i,
  output logic [PA_W-1:0]         rdata_o,
  output seg_ent_t [NSEG-1:0]     tab_o
);
  seg_ent_t [NSEG-1:0] tab_q;
  logic [SEG_BITS-1:0] sel;
  logic [FLD_W-1:0]    fld;

  assign sel = addr_i[CFG_AW-1:FLD_W];
  assign fld = addr_i[FLD_W-1:0];

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tab_q[s] <= seg_reset(s);
      end else if (we_i && sel == SEG_BITS'(s)) begin
        case (fld)
          FLD_BASE:  tab_q[s].base  <= wdata_i;
          FLD_LIMIT: tab_q[s].limit <= wdata_i[LEN_W-1:0];
          FLD_PERM:  {tab_q[s].ok, tab_q[s].x, tab_q[s].w, tab_q[s].r} <= wdata_i[3:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    seg_ent_t e;
    e = tab_q[sel];
    case (fld)
      FLD_BASE:  rdata_o = e.base;
      FLD_LIMIT: rdata_o = PA_W'(e.limit);
      FLD_PERM:  rdata_o = PA_W'({e.ok, e.x, e.w, e.r});
      default:   rdata_o = '0;
    endcase
  end

  assign tab_o = tab_q;
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_pkg::*;
(
  input  seg_ent_t          ent_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        acc_i,
  output fault_e            fault_o,
  output logic [PA_W-1:0]   paddr_o
);
  logic over;
  logic perm_ok;

  assign over = {1'b0, off_i} >= ent_i.limit;

  always_comb begin
    case (acc_e'(acc_i))
      ACC_READ:  perm_ok = ent_i.r;
      ACC_WRITE: perm_ok = ent_i.w;
      ACC_EXEC:  perm_ok = ent_i.x;
      default:   perm_ok = 1'b0;
    endcase
  end

  // priority: invalid, bounds, protection
  always_comb begin
    if (!ent_i.ok)     fault_o = FLT_INVALID;
    else if (over)     fault_o = FLT_BOUNDS;
    else if (!perm_ok) fault_o = FLT_PROT;
    else               fault_o = FLT_NONE;
  end

  assign paddr_o = ent_i.base + PA_W'(off_i);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [1:0]        req_acc_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [PA_W-1:0]   cfg_wdata_i,
  output logic [PA_W-1:0]   cfg_rdata_o,
  output logic              paddr_vld_o,
  output logic [PA_W-1:0]   paddr_o,
  output logic [1:0]        fault_o
);
  seg_ent_t [NSEG-1:0] tab_q;
  fault_e              flt;
  logic [PA_W-1:0]     pa;
  logic                hit;
  logic                vld_q;
  logic [PA_W-1:0]     pa_q;
  fault_e              flt_q;

  seg_table u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .tab_o   (tab_q)
  );

  seg_check u_check (
    .ent_i   (tab_q[req_vaddr_i[VA_W-1:OFF_W]]),
    .off_i   (req_vaddr_i[OFF_W-1:0]),
    .acc_i   (req_acc_i),
    .fault_o (flt),
    .paddr_o (pa)
  );

  assign hit = req_valid_i && (flt == FLT_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      pa_q  <= '0;
      flt_q <= FLT_NONE;
    end else begin
      vld_q <= hit;
      pa_q  <= hit ? pa : '0;
      flt_q <= req_valid_i ? flt : FLT_NONE;
    end
  end

  assign paddr_vld_o = vld_q;
  assign paddr_o     = pa_q;
  assign fault_o     = flt_q;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import seg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [VA_W-1:0]     req_vaddr_i,
  input  seg_ent_t [NSEG-1:0] tab_q,
  input  logic                paddr_vld_o,
  input  logic [PA_W-1:0]     paddr_o,
  input  logic [1:0]          fault_o
);
  seg_ent_t         ent;
  logic [OFF_W-1:0] off;

  assign ent = tab_q[req_vaddr_i[VA_W-1:OFF_W]];
  assign off = req_vaddr_i[OFF_W-1:0];

  p_no_fault_with_vld_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paddr_vld_o |-> fault_o == 2'd0);

  p_req_resolves_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (paddr_vld_o || fault_o != 2'd0));

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!paddr_vld_o && fault_o == 2'd0));

  p_addr_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !paddr_vld_o |-> paddr_o == '0);

  p_invalid_seg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !ent.ok) |=> fault_o == 2'd2);

  p_bounds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ent.ok && ({1'b0, off} >= ent.limit)) |=> fault_o == 2'd1);
endmodule

bind seg_xlate seg_xlate_chk u_chk (.*);

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;
  localparam time CYC = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [13:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        paddr_vld;
  logic [15:0] paddr;
  logic [1:0]  fault;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic [15:0] m_base [4];
  logic [12:0] m_len  [4];
  logic [3:0]  m_perm [4]; // {ok,x,w,r}

  always #(CYC/2) clk = ~clk;

  seg_xlate uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_acc_i(req_acc),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata),
    .paddr_vld_o(paddr_vld), .paddr_o(paddr), .fault_o(fault)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_fault(input logic [1:0] s, input logic [11:0] o, input logic [1:0] a);
    logic pok;
    case (a)
      2'd0: pok = m_perm[s][0];
      2'd1: pok = m_perm[s][1];
      2'd2: pok = m_perm[s][2];
      default: pok = 1'b0;
    endcase
    if (!m_perm[s][3]) return 2'd2;
    if ({1'b0, o} >= m_len[s]) return 2'd1;
    if (!pok) return 2'd3;
    return 2'd0;
  endfunction

  task automatic model_reset();
    m_base[0] = 16'h4000; m_len[0] = 13'h700;  m_perm[0] = 4'b1101;
    m_base[1] = 16'h0000; m_len[1] = 13'h500;  m_perm[1] = 4'b1011;
    m_base[2] = 16'h0000; m_len[2] = 13'h000;  m_perm[2] = 4'b0000;
    m_base[3] = 16'h2000; m_len[3] = 13'h1000; m_perm[3] = 4'b1011;
  endtask

  task automatic model_write(input logic [1:0] s, input logic [1:0] f, input logic [15:0] d);
    case (f)
      2'd0: m_base[s] = d;
      2'd1: m_len[s]  = d[12:0];
      2'd2: m_perm[s] = d[3:0];
      default: ;
    endcase
  endtask

  task automatic cfg_wr(input logic [1:0] s, input logic [1:0] f, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {s, f}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(s, f, d);
  endtask

  task automatic cfg_rd(input string rq, input logic [1:0] s, input logic [1:0] f);
    logic [15:0] e;
    case (f)
      2'd0: e = m_base[s];
      2'd1: e = {3'b0, m_len[s]};
      2'd2: e = {12'b0, m_perm[s]};
      default: e = '0;
    endcase
    @(negedge clk);
    cfg_addr = {s, f};
    #1;
    chk(rq, cfg_rdata, e);
  endtask

  // request at a negedge, result checked at the following negedge
  task automatic xlate(input string rq, input logic [1:0] s, input logic [11:0] o, input logic [1:0] a);
    logic [1:0]  ef;
    logic [15:0] ea;
    ef = exp_fault(s, o, a);
    ea = (ef == 2'd0) ? m_base[s] + {4'b0, o} : 16'h0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {s, o}; req_acc = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({rq, " fault"}, fault, ef);
    chk({rq, " vld"}, paddr_vld, ef == 2'd0);
    chk({rq, " paddr"}, paddr, ea);
  endtask

  initial begin
    #(CYC * 150000);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'h5E61_0007;
    void'($urandom(seed));
    model_reset();
    #(CYC * 2);
    @(negedge clk);
    chk("R8 reset vld", paddr_vld, 1'b0);
    chk("R8 reset fault", fault, 2'd0);
    chk("R9 reset paddr", paddr, 16'h0);
    rst_n = 1'b1;

    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 4; f++)
        cfg_rd("R1 reset table", 2'(s), 2'(f));

    xlate("R2 code exec", 2'd0, 12'h240, 2'd2);
    xlate("R2 data read", 2'd1, 12'h108, 2'd0);
    xlate("R2 stack write top", 2'd3, 12'hFFF, 2'd1);
    xlate("R3 code last", 2'd0, 12'h6FF, 2'd0);
    xlate("R3 code over", 2'd0, 12'h700, 2'd0);
    xlate("R4 heap read", 2'd2, 12'h000, 2'd0);
    xlate("R5 code write", 2'd0, 12'h010, 2'd1);
    xlate("R5 data exec", 2'd1, 12'h010, 2'd2);
    xlate("R5 acc3", 2'd3, 12'h010, 2'd3);
    xlate("R6 invalid over bounds", 2'd2, 12'hFFF, 2'd1);
    xlate("R6 bounds over prot", 2'd0, 12'h800, 2'd1);

    // idle cycle
    @(negedge clk);
    @(negedge clk);
    chk("R8 idle vld", paddr_vld, 1'b0);
    chk("R8 idle fault", fault, 2'd0);

    // R7: write and translate in same cycle -> old contents
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {2'd3, 2'd0}; cfg_wdata = 16'h1000;
    req_valid = 1'b1; req_vaddr = {2'd3, 12'h010}; req_acc = 2'd0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R7 same-cycle old base", paddr, 16'h2010);
    model_write(2'd3, 2'd0, 16'h1000);
    xlate("R7 new base", 2'd3, 12'h010, 2'd0);

    // R7 field behaviours, R2 wrap
    cfg_wr(2'd2, 2'd0, 16'hF800);
    cfg_wr(2'd2, 2'd1, 16'hFFFF);
    cfg_wr(2'd2, 2'd2, 16'hFFF9);
    cfg_wr(2'd2, 2'd3, 16'hFFFF);
    cfg_rd("R7 len truncate", 2'd2, 2'd1);
    cfg_rd("R7 perm field", 2'd2, 2'd2);
    cfg_rd("R7 field3 zero", 2'd2, 2'd3);
    xlate("R2 wrap", 2'd2, 12'hFFF, 2'd0);
    xlate("R5 heap no write", 2'd2, 12'h000, 2'd1);
    cfg_wr(2'd1, 2'd1, 16'h0000);
    xlate("R3 zero length", 2'd1, 12'h000, 2'd0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 8 == 0) begin
        logic [1:0] rs;
        logic [1:0] rf;
        rs = 2'($urandom);
        rf = 2'($urandom);
        cfg_wr(rs, rf, (rf == 2'd2) ? 16'($urandom % 16 | 8) : 16'($urandom));
        cfg_rd("R7 random readback", rs, rf);
      end else begin
        logic [1:0]  rs;
        logic [11:0] ro;
        rs = 2'($urandom);
        if ($urandom % 2 == 0 && m_len[rs] != 0 && m_len[rs] <= 13'h1000)
          ro = 12'(m_len[rs] - 13'($urandom % 2 + 1) + 13'($urandom % 2));
        else
          ro = 12'($urandom);
        xlate("R2 R3 R5 R6 random", rs, ro, 2'($urandom));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule